// File: doc/BRIEF.md
# Region Decode Validator

This block works out where each base address region of a configuration header is decoded. It handles up to six base regions plus one expansion ROM region. Each region has a raw register value, a power-of-two size and a type (I/O or memory). The ROM region is always memory. The block applies the command register's I/O and memory enables and then the rules that reject a mapping. For every region it keeps a record: a mapped flag and, when mapped, the aligned base address. An unmapped region is shown by the flag alone, and its recorded address is zero.

A one-cycle `recompute` strobe starts a scan. The state machine has three states:

- `ST_IDLE`: waits for the strobe. The transition *start* leads to `ST_SCAN`.
- `ST_SCAN`: evaluates one region per clock, in order from slot 0 to the ROM slot. The transition *advance* stays in `ST_SCAN`. The transition *last* leads to `ST_DONE` after the ROM slot.
- `ST_DONE`: raises `scan_done` for one cycle. The transition *finish* returns to `ST_IDLE`.

When a region's newly evaluated result differs from its record, the record is rewritten. In the next cycle a single-cycle change pulse carries the slot number and the old and new flag and address. Slot n corresponds to the header register at offset 0x10 + 4·n, and the ROM slot to offset 0x30. Routing of accesses to those addresses lies outside the block.

Top module: `region_map_tracker`

## Requirements
- R1: After reset every region is unmapped with recorded address 0, `busy` is low and no change pulse is emitted.
- R2: A region whose size input is 0 is never mapped.
- R3: An I/O region (type bit 1) can be mapped only while `io_space_en` is 1. A memory region (type bit 0, and always the ROM slot) can be mapped only while `mem_space_en` is 1.
- R4: The decoded base is the register value with its low log2(size) bits forced to zero. The last address is base + size − 1, computed modulo 2^32.
- R5: A region is unmapped when its base is zero or when its last address is not above its base. So a size of 1 never maps. A mapped region never reports address 0.
- R6: An I/O region is unmapped when its last address is 0x10000 or higher.
- R7: A memory region is unmapped when its last address is 0xFFFFFFFF.
- R8: The ROM slot (index 6 with the default parameters) is unmapped unless bit 0 of its register value is 1.
- R9: A change pulse is raised only for a region whose new flag or address differs from its record. It lasts one cycle and carries the slot index, the old and new flags and the old and new addresses. The record and the `mapped`/`map_addr` outputs update in the same edge.
- R10: A strobe seen in `ST_IDLE` starts a scan. The change result for slot k appears k+2 cycles after the strobe edge, `scan_done` is high in cycle NUM_BARS+2, and `busy` falls one cycle later. A strobe during a scan is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recompute | input | 1 | Start a scan (taken only when idle) |
| io_space_en | input | 1 | Command register I/O decode enable |
| mem_space_en | input | 1 | Command register memory decode enable |
| reg_value | input | 7*32 | Raw register value per slot, slot n at bits [32n+31:32n], ROM last |
| reg_size | input | 7*32 | Region size per slot (0 or a power of two) |
| reg_is_io | input | 6 | Type per base slot, 1 = I/O |
| mapped | output | 7 | Recorded mapped flag per slot |
| map_addr | output | 7*32 | Recorded base per slot, 0 when unmapped |
| busy | output | 1 | High in `ST_SCAN` and `ST_DONE` |
| scan_done | output | 1 | One-cycle pulse in `ST_DONE` |
| chg_pulse | output | 1 | One-cycle change event |
| chg_region | output | 3 | Slot of the change event |
| chg_old_valid | output | 1 | Flag before the change |
| chg_old_addr | output | 32 | Address before the change |
| chg_new_valid | output | 1 | Flag after the change |
| chg_new_addr | output | 32 | Address after the change |

## Verification
A wrong scan index or a stuck state would show up as a change event tagged with the wrong slot, as an event in the wrong cycle, or as `scan_done` arriving early, late or twice. Each of these is visible within one scan of eight cycles. A wrong record would show up as a spurious or missing pulse on the next scan, and as a mismatch on `mapped`/`map_addr` right after `scan_done`. Inputs are held steady during a scan, so every event can be predicted slot by slot.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;
endpackage

// File: rtl/region_eval.sv
// Combinational decode of one region: alignment plus the rejection rules.
module region_eval #(
    parameter int AW       = 32,
    parameter int IO_LIMIT = 32'h0001_0000
) (
    input  logic [AW-1:0] raw,
    input  logic [AW-1:0] size,
    input  logic          is_io,
    input  logic          is_rom,
    input  logic          io_en,
    input  logic          mem_en,
    output logic          valid,
    output logic [AW-1:0] base
);
    localparam logic [AW-1:0] ALL_ONES = '1;
    localparam logic [AW-1:0] IO_TOP   = AW'(IO_LIMIT);

    logic [AW-1:0] aligned;
    logic [AW-1:0] last;
    logic          implemented;
    logic          enabled;
    logic          rom_ok;
    logic          rejected;

    always_comb begin
        aligned     = raw & ~(size - AW'(1));
        last        = aligned + size - AW'(1);
        implemented = (size != '0);
        enabled     = is_io ? io_en : mem_en;
        rom_ok      = !is_rom || raw[0];
        rejected    = (last <= aligned) || (aligned == '0) ||
                      (is_io ? (last >= IO_TOP) : (last == ALL_ONES));
        valid       = implemented && enabled && rom_ok && !rejected;
        base        = valid ? aligned : '0;
    end
endmodule

// File: rtl/region_table.sv
// Per-region record of the last reported decode result.
module region_table #(
    parameter int NREG = 7,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    output logic [NREG-1:0]  mapped,
    output logic [NREG*AW-1:0] map_addr
);
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mapped[g]              <= 1'b0;
                map_addr[g*AW +: AW]   <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                mapped[g]              <= wr_valid;
                map_addr[g*AW +: AW]   <= wr_addr;
            end
        end
    end
endmodule

// File: rtl/region_map_tracker.sv
module region_map_tracker #(
    parameter int NUM_BARS = 6,
    parameter int AW       = 32,
    localparam int NREG    = NUM_BARS + 1,
    localparam int IW      = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               recompute,
    input  logic               io_space_en,
    input  logic               mem_space_en,
    input  logic [NREG*AW-1:0] reg_value,
    input  logic [NREG*AW-1:0] reg_size,
    input  logic [NUM_BARS-1:0] reg_is_io,
    output logic [NREG-1:0]    mapped,
    output logic [NREG*AW-1:0] map_addr,
    output logic               busy,
    output logic               scan_done,
    output logic               chg_pulse,
    output logic [IW-1:0]      chg_region,
    output logic               chg_old_valid,
    output logic [AW-1:0]      chg_old_addr,
    output logic               chg_new_valid,
    output logic [AW-1:0]      chg_new_addr
);
    import rmap_pkg::*;

    localparam logic [IW-1:0] ROM_IDX = IW'(NUM_BARS);

    scan_state_e   state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    logic [NREG-1:0] io_ext;
    logic [AW-1:0]   sel_raw, sel_size, ev_addr, old_addr;
    logic            sel_io, sel_rom, ev_valid, old_valid, differ, wr_en;

    // Selected slot inputs and its current record.
    always_comb begin
        io_ext    = {1'b0, reg_is_io};
        sel_raw   = reg_value[idx_q*AW +: AW];
        sel_size  = reg_size[idx_q*AW +: AW];
        sel_io    = io_ext[idx_q];
        sel_rom   = (idx_q == ROM_IDX);
        old_valid = mapped[idx_q];
        old_addr  = map_addr[idx_q*AW +: AW];
        differ    = (ev_valid != old_valid) || (ev_addr != old_addr);
        wr_en     = (state_q == ST_SCAN) && differ;
    end

    region_eval #(.AW(AW)) u_eval (
        .raw    (sel_raw),
        .size   (sel_size),
        .is_io  (sel_io),
        .is_rom (sel_rom),
        .io_en  (io_space_en),
        .mem_en (mem_space_en),
        .valid  (ev_valid),
        .base   (ev_addr)
    );

    region_table #(.NREG(NREG), .AW(AW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (idx_q),
        .wr_valid (ev_valid),
        .wr_addr  (ev_addr),
        .mapped   (mapped),
        .map_addr (map_addr)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (recompute) begin
                    state_d = ST_SCAN;
                    idx_d   = '0;
                end
            end
            ST_SCAN: begin
                if (idx_q == ROM_IDX) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = idx_q + IW'(1);
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Registered change event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_pulse     <= 1'b0;
            chg_region    <= '0;
            chg_old_valid <= 1'b0;
            chg_old_addr  <= '0;
            chg_new_valid <= 1'b0;
            chg_new_addr  <= '0;
        end else begin
            chg_pulse <= wr_en;
            if (wr_en) begin
                chg_region    <= idx_q;
                chg_old_valid <= old_valid;
                chg_old_addr  <= old_addr;
                chg_new_valid <= ev_valid;
                chg_new_addr  <= ev_addr;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        scan_done = (state_q == ST_DONE);
    end
endmodule

// File: rtl/region_map_tracker_chk.sv
module region_map_tracker_chk #(
    parameter int NUM_BARS = 6,
    parameter int AW       = 32,
    localparam int NREG    = NUM_BARS + 1,
    localparam int IW      = $clog2(NREG)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NREG-1:0]    mapped,
    input logic [NREG*AW-1:0] map_addr,
    input logic               busy,
    input logic               scan_done,
    input logic               chg_pulse,
    input logic [IW-1:0]      chg_region,
    input logic               chg_old_valid,
    input logic [AW-1:0]      chg_old_addr,
    input logic               chg_new_valid,
    input logic [AW-1:0]      chg_new_addr
);
    assert_chg_in_scan_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> busy);

    assert_chg_differs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> ((chg_old_valid != chg_new_valid) || (chg_old_addr != chg_new_addr)));

    assert_chg_matches_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> (mapped[chg_region] == chg_new_valid &&
                       map_addr[chg_region*AW +: AW] == chg_new_addr));

    assert_mapped_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pulse && chg_new_valid) |-> (chg_new_addr != '0));

    assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !busy);

    assert_table_stable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(mapped) && $stable(map_addr)));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pulse && !busy) |-> 1'b0);
endmodule

bind region_map_tracker region_map_tracker_chk #(.NUM_BARS(NUM_BARS), .AW(AW)) u_chk (.*);

// File: tb/region_map_tracker_test.sv
module region_map_tracker_test;
    localparam int NB = 6;
    localparam int NR = NB + 1;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic recompute = 1'b0, io_en = 1'b0, mem_en = 1'b0;
    logic [NR*AW-1:0] reg_value = '0, reg_size = '0;
    logic [NB-1:0] reg_is_io = '0;
    logic [NR-1:0] mapped;
    logic [NR*AW-1:0] map_addr;
    logic busy, scan_done, chg_pulse, chg_old_valid, chg_new_valid;
    logic [2:0] chg_region;
    logic [AW-1:0] chg_old_addr, chg_new_addr;

    int checks = 0, errors = 0;
    logic        m_valid [NR];
    logic [31:0] m_addr  [NR];

    always #10 clk = ~clk;

    region_map_tracker uut (
        .clk(clk), .rst_n(rst_n), .recompute(recompute),
        .io_space_en(io_en), .mem_space_en(mem_en),
        .reg_value(reg_value), .reg_size(reg_size), .reg_is_io(reg_is_io),
        .mapped(mapped), .map_addr(map_addr), .busy(busy), .scan_done(scan_done),
        .chg_pulse(chg_pulse), .chg_region(chg_region),
        .chg_old_valid(chg_old_valid), .chg_old_addr(chg_old_addr),
        .chg_new_valid(chg_new_valid), .chg_new_addr(chg_new_addr));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected decode per the requirements: {valid, addr}.
    function automatic logic [32:0] expect_slot(input int k);
        logic [31:0] v, s, b, l;
        bit io, ok;
        v  = reg_value[k*AW +: AW];
        s  = reg_size[k*AW +: AW];
        io = (k < NB) ? reg_is_io[k] : 1'b0;
        if (s == 0) return 33'd0;                          // R2
        if (io ? !io_en : !mem_en) return 33'd0;            // R3
        if (k == NB && !v[0]) return 33'd0;                 // R8
        b = v & ~(s - 1);                                   // R4
        l = b + s - 1;
        ok = (l > b) && (b != 0);                           // R5
        if (io && l >= 32'h1_0000) ok = 0;                  // R6
        if (!io && l == 32'hFFFF_FFFF) ok = 0;              // R7
        return ok ? {1'b1, b} : 33'd0;
    endfunction

    task automatic set_slot(input int k, input logic [31:0] v, input logic [31:0] s, input bit io);
        reg_value[k*AW +: AW] = v;
        reg_size[k*AW +: AW]  = s;
        if (k < NB) reg_is_io[k] = io;
    endtask

    task automatic scan(input bit extra_strobe, input string tag);
        logic [32:0] e;
        bit diff;
        @(negedge clk) recompute = 1'b1;
        @(negedge clk) recompute = 1'b0;
        chk(busy === 1'b1, {"R10 busy after strobe ", tag}, 64'(busy), 64'd1);
        for (int n = 2; n <= NR + 1; n++) begin
            @(negedge clk);
            e    = expect_slot(n - 2);
            diff = (e[32] != m_valid[n-2]) || (e[31:0] != m_addr[n-2]);
            chk(chg_pulse === diff, {"R9 pulse presence ", tag}, 64'(chg_pulse), 64'(diff));
            if (chg_pulse && diff) begin
                chk(chg_region === 3'(n - 2), {"R10 pulse slot ", tag}, 64'(chg_region), 64'(n - 2));
                chk({chg_old_valid, chg_old_addr} === {m_valid[n-2], m_addr[n-2]},
                    {"R9 old value ", tag}, 64'({chg_old_valid, chg_old_addr}), 64'({m_valid[n-2], m_addr[n-2]}));
                chk({chg_new_valid, chg_new_addr} === e, {"R4 new value ", tag},
                    64'({chg_new_valid, chg_new_addr}), 64'(e));
            end
            m_valid[n-2] = e[32];
            m_addr[n-2]  = e[31:0];
            chk(scan_done === (n == NR + 1), {"R10 done timing ", tag}, 64'(scan_done), 64'(n == NR + 1));
            if (extra_strobe && n == 3) recompute = 1'b1;
            if (n == 4) recompute = 1'b0;
        end
        @(negedge clk);
        chk(busy === 1'b0, {"R10 idle after done ", tag}, 64'(busy), 64'd0);
        chk(chg_pulse === 1'b0, {"R9 no pulse after scan ", tag}, 64'(chg_pulse), 64'd0);
        for (int k = 0; k < NR; k++)
            chk({mapped[k], map_addr[k*AW +: AW]} === {m_valid[k], m_addr[k]},
                {"R9 table ", tag}, 64'({mapped[k], map_addr[k*AW +: AW]}), 64'({m_valid[k], m_addr[k]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < NR; k++) begin m_valid[k] = 0; m_addr[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mapped === '0, "R1 reset mapped", 64'(mapped), 64'd0);
        chk(map_addr === '0, "R1 reset addr", 64'(map_addr[63:0]), 64'd0);
        chk(busy === 1'b0 && chg_pulse === 1'b0, "R1 reset idle", 64'({busy, chg_pulse}), 64'd0);

        // Directed corners, all decoding enabled.
        io_en = 1; mem_en = 1;
        set_slot(0, 32'h0000_1234, 32'h100, 1);      // I/O valid base 0x1200 (R4)
        set_slot(1, 32'h8000_0000, 32'h0, 0);        // size 0 (R2)
        set_slot(2, 32'h0000_FF05, 32'h100, 1);      // I/O last 0xFFFF valid (R6)
        set_slot(3, 32'h0001_0000, 32'h10, 1);       // I/O last past limit (R6)
        set_slot(4, 32'hFFFF_F000, 32'h1000, 0);     // memory last all ones (R7)
        set_slot(5, 32'h0000_0ABC, 32'h1000, 0);     // base zero (R5)
        set_slot(6, 32'hC000_0000, 32'h1_0000, 0);   // ROM enable clear (R8)
        scan(1'b1, "directed A");
        chk(mapped === 7'b0000101, "R8 R6 R7 mapped set A", 64'(mapped), 64'h05);
        scan(1'b0, "repeat A");                      // R9: no pulses expected

        set_slot(6, 32'hC000_0001, 32'h1_0000, 0);   // ROM enabled (R8)
        set_slot(4, 32'hFFFF_E000, 32'h1000, 0);     // just below all ones (R7)
        set_slot(5, 32'h0000_5000, 32'h1, 0);        // size 1: last == base (R5)
        scan(1'b0, "directed B");
        chk(map_addr[6*AW +: AW] === 32'hC000_0000, "R8 ROM base", 64'(map_addr[6*AW +: AW]), 64'hC000_0000);

        io_en = 0;                                   // R3
        scan(1'b0, "io off");
        io_en = 1; mem_en = 0;
        scan(1'b0, "mem off");
        mem_en = 1;
        scan(1'b0, "both on");

        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < NR; k++) begin
                int sh;
                bit io;
                sh = $urandom % 24;
                io = $urandom % 2;
                set_slot(k, io ? ($urandom & 32'h1_FFFF) : $urandom,
                         (sh >= 21) ? 32'h0 : (32'h1 << (io ? sh % 18 : sh)), io);
            end
            io_en  = ($urandom % 4) != 0;
            mem_en = ($urandom % 4) != 0;
            scan(r % 5 == 0, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule